// File: doc/BRIEF.md
# SPI Flash Configuration Read Master

This block starts a continuous read from an external serial flash so that a configuration image can be streamed into the chip. After reset it holds the flash chip select low and the serial clock idle. When the initialization-complete input goes high, chip select is pulled high for a fixed window counted in system clock cycles. It then returns low and the block sends a read command. The command is an 8-bit opcode followed by a start address, both sent MSB first.

Two command formats exist, chosen by a strap input. The standard format sends the fixed opcode 0x03 and a 24-bit start address taken from an input. A non-zero address lets a partial reload begin in the middle of the flash. The extended format sends an opcode taken from an 8-bit parallel bus and a 32-bit address of zero. The bus value is taken in the last cycle of the chip-select-high window. After the command, incoming bits are packed into bytes and handed to a byte interface with a one-cycle strobe. This continues until the stop input ends the read.

The controller has five states. PWRUP holds chip select low. GAP is the timed chip-select-high window. CMD shifts out the opcode and address. DATA assembles received bytes. DONE holds chip select high until the next reset. The transitions are:
- PWRUP to GAP when `init_done` is high.
- GAP to CMD after `WIN_CYCLES` cycles, which also loads the command word.
- CMD to DATA on the serial-clock fall that follows the last command bit.
- CMD or DATA to DONE when `stop` is high.

Top module: `spi_cfg_reader`

## Requirements
- R1: While reset has been released and `init_done` has not yet been seen high, `spi_cs_n` is 0, `spi_sck` is 0 and `byte_valid` is 0.
- R2: After `init_done` is sampled high, `spi_cs_n` is 1 for exactly `WIN_CYCLES` system cycles and then returns to 0. At the default of 30 cycles with a 5 ns clock, this is 150 ns, which lies within 100 to 200 ns.
- R3: `spi_sck` stays 0 whenever `spi_cs_n` is 1. The first rising edge of `spi_sck` comes only after `spi_cs_n` has returned to 0.
- R4: `spi_mosi` changes only while `spi_sck` is low, so it is updated on falling edges. Command and address bits are sent MSB first.
- R5: With `ext_mode` = 0, the first 32 bits sampled on `spi_sck` rising edges are 8'h03 followed by `start_addr[23:0]`, including non-zero addresses.
- R6: With `ext_mode` = 1, the first 40 bits are the value of `op_bus` in the last window cycle, followed by 32 zero bits. Later changes to `op_bus` and the value of `start_addr` have no effect.
- R7: After the command, `spi_miso` is sampled on each `spi_sck` rising edge, MSB first. Each group of 8 bits appears on `byte_data` with `byte_valid` high for exactly one cycle.
- R8: The first data bit is the one sampled on the first rising edge after the last command bit.
- R9: When `stop` is high during the command or data phase, `spi_cs_n` is 1 and `spi_sck` is 0 from the next cycle on. No further bytes are produced until reset.
- R10: `spi_sck` has a period of 2*`HALF_DIV` system cycles, which is 20 ns at the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| init_done | input | 1 | Initialization complete; starts the sequence |
| ext_mode | input | 1 | 0 = standard command format, 1 = extended format |
| start_addr | input | 24 | Start address for the standard format |
| op_bus | input | 8 | Parallel opcode source for the extended format |
| stop | input | 1 | Ends the read and releases chip select |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial command/address output |
| spi_miso | input | 1 | Serial data from the flash |
| byte_data | output | 8 | Assembled data byte |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |

## Verification
The hardest case to reach from the ports is the handover from command to data. The first data bit has to line up with the rising edge that follows the last address bit, and the two formats put that boundary at different bit counts. The bench therefore models the flash behaviourally. It counts rising edges of the serial clock, captures the command from them, and starts driving a known byte pattern on the falling edge right after the 32nd or 40th edge. Any misalignment then shows up as shifted bytes. A second hard case is stopping in the middle of a byte. The bench waits until a few bytes have arrived, stops a few cycles later, and watches for stray strobes.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_GAP,
        ST_CMD,
        ST_DATA,
        ST_DONE
    } rd_state_t;

    localparam logic [7:0] STD_READ_OP = 8'h03;
endpackage

// File: rtl/spi_cfg_clkgen.sv
module spi_cfg_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [DIV_W-1:0] div_cnt;
    logic             sck_q;
    logic             half_done;

    assign half_done = run && (div_cnt == DIV_W'(HALF_DIV - 1));
    assign rise_tick = half_done && !sck_q;
    assign fall_tick = half_done && sck_q;
    assign sck       = sck_q && run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            sck_q   <= 1'b0;
        end else if (!run) begin
            div_cnt <= '0;
            sck_q   <= 1'b0;
        end else if (half_done) begin
            div_cnt <= '0;
            sck_q   <= !sck_q;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // R10: each rise tick is followed by a high serial clock
    a_r10_rise_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> sck_q);
    // R10: each fall tick is followed by a low serial clock
    a_r10_fall_follows: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick |=> !sck_q);
endmodule

// File: rtl/spi_cfg_cmd_shift.sv
module spi_cfg_cmd_shift #(
    parameter int WORD_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    output logic              mosi
);
    logic [WORD_W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= load_word;
        end else if (shift) begin
            sreg <= {sreg[WORD_W-2:0], 1'b0};
        end
    end

    assign mosi = sreg[WORD_W-1];
endmodule

// File: rtl/spi_cfg_rx.sv
module spi_cfg_rx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              sample,
    input  logic              miso,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid
);
    localparam int BC_W = $clog2(BYTE_W);

    logic [BYTE_W-2:0] acc;
    logic [BC_W-1:0]   bit_cnt;
    logic              last_bit;

    assign last_bit = (bit_cnt == BC_W'(BYTE_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc        <= '0;
            bit_cnt    <= '0;
            byte_data  <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (clr) begin
                acc     <= '0;
                bit_cnt <= '0;
            end else if (sample) begin
                acc <= {acc[BYTE_W-3:0], miso};
                if (last_bit) begin
                    bit_cnt    <= '0;
                    byte_data  <= {acc, miso};
                    byte_valid <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R7: the byte strobe lasts a single cycle
    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);
endmodule

// File: rtl/spi_cfg_reader.sv
module spi_cfg_reader
    import spi_cfg_pkg::*;
#(
    parameter int WIN_CYCLES = 30,
    parameter int HALF_DIV   = 2,
    parameter int STD_ADDR_W = 24,
    parameter int EXT_ADDR_W = 32,
    parameter int OP_W       = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init_done,
    input  logic                  ext_mode,
    input  logic [STD_ADDR_W-1:0] start_addr,
    input  logic [OP_W-1:0]       op_bus,
    input  logic                  stop,
    output logic                  spi_cs_n,
    output logic                  spi_sck,
    output logic                  spi_mosi,
    input  logic                  spi_miso,
    output logic [7:0]            byte_data,
    output logic                  byte_valid
);
    localparam int CMD_W   = OP_W + EXT_ADDR_W;
    localparam int STD_LEN = OP_W + STD_ADDR_W;
    localparam int PAD_W   = CMD_W - STD_LEN;
    localparam int CNT_W   = $clog2(CMD_W + 1);
    localparam int WIN_W   = $clog2(WIN_CYCLES + 1);

    rd_state_t        state, state_nx;
    logic [WIN_W-1:0] win_cnt;
    logic [CNT_W-1:0] cmd_cnt;
    logic [CNT_W-1:0] cmd_len;
    logic             win_last;
    logic             load_cmd;
    logic             shift_cmd;
    logic             cmd_over;
    logic             run_sck;
    logic             rise_tick;
    logic             fall_tick;
    logic             rx_sample;
    logic [CMD_W-1:0] cmd_word;

    assign win_last  = (win_cnt == WIN_W'(WIN_CYCLES - 1));
    assign cmd_over  = (cmd_cnt == cmd_len);
    assign load_cmd  = (state == ST_GAP) && win_last;
    assign shift_cmd = (state == ST_CMD) && fall_tick && !cmd_over;
    assign rx_sample = (state == ST_DATA) && rise_tick && !stop;

    generate
        if (PAD_W > 0) begin : g_pad
            assign cmd_word = ext_mode ? {op_bus, {EXT_ADDR_W{1'b0}}}
                                       : {STD_READ_OP, start_addr, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign cmd_word = ext_mode ? {op_bus, {EXT_ADDR_W{1'b0}}}
                                       : {STD_READ_OP, start_addr};
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PWRUP;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PWRUP: if (init_done) state_nx = ST_GAP;
            ST_GAP:   if (win_last)  state_nx = ST_CMD;
            ST_CMD: begin
                if (stop)                       state_nx = ST_DONE;
                else if (fall_tick && cmd_over) state_nx = ST_DATA;
            end
            ST_DATA:  if (stop) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_DONE;
            default:  state_nx = ST_PWRUP;
        endcase
    end

    // outputs
    always_comb begin
        spi_cs_n = 1'b0;
        run_sck  = 1'b0;
        unique case (state)
            ST_PWRUP: spi_cs_n = 1'b0;
            ST_GAP:   spi_cs_n = 1'b1;
            ST_CMD:   run_sck  = 1'b1;
            ST_DATA:  run_sck  = 1'b1;
            ST_DONE:  spi_cs_n = 1'b1;
            default:  spi_cs_n = 1'b1;
        endcase
    end

    // window and command counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt <= '0;
            cmd_cnt <= '0;
            cmd_len <= '0;
        end else begin
            if (state == ST_GAP) win_cnt <= win_cnt + 1'b1;
            else                 win_cnt <= '0;
            if (load_cmd) begin
                cmd_cnt <= '0;
                cmd_len <= ext_mode ? CNT_W'(CMD_W) : CNT_W'(STD_LEN);
            end else if ((state == ST_CMD) && rise_tick) begin
                cmd_cnt <= cmd_cnt + 1'b1;
            end
        end
    end

    spi_cfg_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_sck),
        .sck      (spi_sck),
        .rise_tick(rise_tick),
        .fall_tick(fall_tick)
    );

    spi_cfg_cmd_shift #(.WORD_W(CMD_W)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_cmd),
        .load_word(cmd_word),
        .shift    (shift_cmd),
        .mosi     (spi_mosi)
    );

    spi_cfg_rx #(.BYTE_W(8)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (load_cmd),
        .sample    (rx_sample),
        .miso      (spi_miso),
        .byte_data (byte_data),
        .byte_valid(byte_valid)
    );

    // R1: while waiting for init, the flash is selected and the clock idle
    a_r1_pwrup_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWRUP) |-> (!spi_cs_n && !spi_sck && !byte_valid));
    // R3: the serial clock never toggles while chip select is high
    a_r3_no_sck_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);
    // R4: the serial output holds while the clock is high
    a_r4_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
    // R9: stop during the read releases chip select on the next cycle
    a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && ((state == ST_CMD) || (state == ST_DATA))) |=> (spi_cs_n && !spi_sck));
    // R9: once finished, no further bytes arrive
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_DONE) && $past(state == ST_DONE)) |-> !byte_valid);
    // R2: the window ends in the command phase
    a_r2_window_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_GAP) && win_last) |=> (state == ST_CMD) && !spi_cs_n);
endmodule

// File: tb/spi_cfg_reader_test.sv
module spi_cfg_reader_test;
    localparam int WIN = 30;
    localparam realtime TCLK = 5ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_done = 1'b0;
    logic        ext_mode = 1'b0;
    logic [23:0] start_addr = '0;
    logic [7:0]  op_bus = '0;
    logic        stop = 1'b0;
    logic        spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;
    logic [7:0]  byte_data;
    logic        byte_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // flash model state
    int          rise_cnt = 0;
    int          cmd_len = 32;
    logic [63:0] cmd_cap = '0;
    realtime     last_rise = 0;
    realtime     sck_period = 0;
    // byte monitor
    logic [7:0]  rx_buf [0:63];
    int          rx_count = 0;

    always #(TCLK/2) clk = ~clk;

    spi_cfg_reader uut (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .ext_mode(ext_mode),
        .start_addr(start_addr), .op_bus(op_bus), .stop(stop),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .byte_data(byte_data), .byte_valid(byte_valid)
    );

    function automatic logic [7:0] pat(int k);
        return 8'h5A ^ 8'(k * 29);
    endfunction

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            if (rise_cnt < cmd_len) cmd_cap = {cmd_cap[62:0], spi_mosi};
            if (rise_cnt > 0) sck_period = $realtime - last_rise;
            last_rise = $realtime;
            rise_cnt  = rise_cnt + 1;
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n && rise_cnt >= cmd_len) begin
            int idx;
            logic [7:0] b;
            idx = rise_cnt - cmd_len;
            b = pat(idx / 8);
            spi_miso = b[7 - (idx % 8)];
        end
    end

    always @(negedge clk) begin
        if (byte_valid && rx_count < 64) begin
            rx_buf[rx_count] = byte_data;
            rx_count = rx_count + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit ext, input logic [23:0] addr, input logic [7:0] op);
        rst_n = 1'b0; init_done = 1'b0; stop = 1'b0;
        ext_mode = ext; start_addr = addr; op_bus = op;
        cmd_len = ext ? 40 : 32;
        rise_cnt = 0; cmd_cap = '0; spi_miso = 1'b0; rx_count = 0; sck_period = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // raise init and measure the window; returns its length in cycles
    task automatic open_window(output int width, output bit sck_seen);
        width = 0; sck_seen = 0;
        @(negedge clk);
        init_done = 1'b1;
        @(negedge clk);
        while (spi_cs_n && width < 1000) begin
            width++;
            if (spi_sck) sck_seen = 1;
            @(negedge clk);
        end
    endtask

    task automatic wait_bytes(input int n);
        int t = 0;
        while (rx_count < n && t < 20000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic test_powerup();
        bit bad = 0;
        do_reset(1'b0, 24'h0, 8'h0);
        for (int i = 0; i < 20; i++) begin
            if (spi_cs_n || spi_sck || byte_valid) bad = 1;
            @(negedge clk);
        end
        chk(!bad, "R1 idle before init", {spi_cs_n, spi_sck, byte_valid}, 0);
    endtask

    task automatic test_standard(input logic [23:0] addr);
        int w; bit s; bit bad = 0;
        do_reset(1'b0, addr, 8'hC3);
        open_window(w, s);
        chk(w == WIN, "R2 window length", w, WIN);
        chk((w * 5 >= 100) && (w * 5 <= 200), "R2 window ns", w * 5, 150);
        chk(!s, "R3 sck low in window", s, 0);
        chk(rise_cnt == 0, "R3 no edge before cs low", rise_cnt, 0);
        wait_bytes(4);
        chk(cmd_cap[31:0] == {8'h03, addr}, "R5 std command", cmd_cap[31:0], {8'h03, addr});
        for (int k = 0; k < 4; k++)
            if (rx_buf[k] != pat(k)) bad = 1;
        chk(rx_count >= 4 && !bad, "R7 R8 std bytes", rx_buf[0], pat(0));
        chk(sck_period == 20ns, "R10 sck period", longint'(sck_period / 1ns), 20);
    endtask

    task automatic test_extended();
        int w; bit s; bit bad = 0;
        do_reset(1'b1, 24'hABCDEF, 8'h11);
        @(negedge clk);
        init_done = 1'b1;
        @(negedge clk);
        op_bus = 8'h3B;
        while (spi_cs_n) @(negedge clk);
        op_bus = 8'hFF;
        wait_bytes(5);
        chk(cmd_cap[39:0] == {8'h3B, 32'h0}, "R6 ext command", cmd_cap[39:0], {8'h3B, 32'h0});
        for (int k = 0; k < 5; k++)
            if (rx_buf[k] != pat(k)) bad = 1;
        chk(rx_count >= 5 && !bad, "R8 ext byte alignment", rx_buf[0], pat(0));
    endtask

    task automatic test_stop();
        int w; bit s; int held; bit bad = 0;
        do_reset(1'b0, 24'h000100, 8'h0);
        open_window(w, s);
        wait_bytes(2);
        repeat (5) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R9 cs released", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R9 sck idle", spi_sck, 0);
        stop = 1'b0;
        held = rx_count;
        for (int i = 0; i < 200; i++) begin
            if (!spi_cs_n || spi_sck) bad = 1;
            @(negedge clk);
        end
        chk(rx_count == held, "R9 no bytes after stop", rx_count, held);
        chk(!bad, "R9 stays released", bad, 0);
    endtask

    task automatic test_valid_width();
        int hi = 0; int maxhi = 0;
        do_reset(1'b0, 24'h0, 8'h0);
        @(negedge clk);
        init_done = 1'b1;
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            if (byte_valid) hi++; else hi = 0;
            if (hi > maxhi) maxhi = hi;
        end
        chk(maxhi == 1, "R7 strobe width", maxhi, 1);
    endtask

    task automatic test_mosi_timing();
        bit bad = 0; logic prev_m; logic prev_s;
        do_reset(1'b0, 24'hF0F0F0, 8'h0);
        @(negedge clk);
        init_done = 1'b1;
        prev_m = spi_mosi; prev_s = spi_sck;
        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            if (prev_s && spi_sck && (spi_mosi != prev_m)) bad = 1;
            prev_m = spi_mosi; prev_s = spi_sck;
        end
        chk(!bad, "R4 mosi stable while sck high", bad, 0);
        chk(cmd_cap[31:0] == {8'h03, 24'hF0F0F0}, "R4 R5 msb first", cmd_cap[31:0],
            {8'h03, 24'hF0F0F0});
    endtask

    initial begin
        #(TCLK * 150000);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        test_powerup();
        test_standard(24'h000000);
        test_standard(24'h123456);
        test_extended();
        test_stop();
        test_valid_width();
        test_mosi_timing();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule